// File: doc/BRIEF.md
# Address and Data Break Comparator Group

This block watches three processor buses: the instruction fetch address, the operand access address and the data value. It raises break events when a configured condition matches. It holds four point comparators, arranged as two pairs. Each pair is steered to one of the three buses. A pair works in one of three ways:

- as two independent exact points;
- as points where a per-comparator mask excludes chosen bits from the compare;
- as one inclusive range whose bounds are its two point values.

The two pairs can also be joined, so that a break is recorded only when both pairs hit in the same cycle. The intended use is an operand-address condition on pair 0 combined with a data-value condition on pair 1.

Every hit sets a sticky status bit for its comparator. The first hit seen while no status bit is pending latches the instruction and operand addresses on the buses in that cycle. An interrupt line is the OR of the status bits. Software configures the block, reads status and captures, and clears status by writing ones through a plain word-addressed register port.

The watched buses are observe-only streams carrying a valid strobe and no ready. The comparators never apply back-pressure, and every beat presented with its strobe high is evaluated in that cycle. Register reads are combinational from `reg_addr`. Writes take effect at the clock edge where `reg_we` is high.

Top module: `brk_cmp_group`

## Requirements
- R1: After reset, the status word, both capture registers and `brk_irq` are all zero.
- R2: Each pair's bus select works as follows: 0 selects the instruction address, 1 the operand address, 2 the data value and 3 no bus. When range mode is off, comparator c sets status bit c one cycle after the selected bus presents a value equal to point register c.
- R3: A pair whose selected bus has its valid strobe low sets no status bit. A value equal to a point but presented on an unselected bus also sets no status bit.
- R4: When a comparator's mask enable is set, bits that are 1 in its mask register are excluded from the compare. When mask enable is clear, the mask register has no effect.
- R5: In range mode, pair p sets status bits 2p and 2p+1 together when the lower point (2p) ≤ value ≤ the upper point (2p+1), using unsigned 32-bit compares. Both bounds are inclusive. Masks are ignored in this mode. A lower bound above the upper bound never matches.
- R6: When the combine bit is set, hits from a cycle are recorded only if at least one comparator of pair 0 and at least one comparator of pair 1 hit in that cycle.
- R7: Status bits stay set until a write of 1 to their position at word 9. A hit in the same cycle as the clear of that bit leaves the bit set. Writing 0 to a bit leaves it unchanged.
- R8: When a hit occurs while the status word is zero, word 10 latches the instruction address and word 11 latches the operand address present in that cycle. Later hits leave both capture registers unchanged until the status word is zero again.
- R9: `brk_irq` is high exactly when any status bit is set.
- R10: The register words read back as follows:
  - Words 0–3 hold the point values and words 4–7 the masks.
  - Word 8 is the control word. Pair p uses bits 8p+1:8p for the bus select, bit 8p+2 for range enable, bit 8p+3 for the mask enable of comparator 2p and bit 8p+4 for the mask enable of comparator 2p+1. Bit 16 is the combine bit.
  - Undefined control bits and unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ifetch_vld | input | 1 | Instruction fetch valid strobe |
| ifetch_addr | input | 32 | Instruction fetch address |
| opnd_vld | input | 1 | Operand access valid strobe |
| opnd_addr | input | 32 | Operand access address |
| data_vld | input | 1 | Data value valid strobe |
| data_val | input | 32 | Data value |
| brk_irq | output | 1 | Break pending interrupt |

## Verification
A software clear of a status bit can land in the same cycle as a new hit on that same comparator. The first-hit address capture can also land in the same cycle as a clear of the last pending bit. The bench provokes the first case directly: it writes a clear to word 9 while the combined operand and data buses present matching values. It then expects the bit to survive, and expects a later clear with the buses idle to remove it. The random phase issues clears and hits at random with a fixed seed. It judges every cycle's status, interrupt and, periodically, the captures against a bench model. In that model, set wins over clear and capture looks only at the status held before the edge.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;

  typedef enum logic [1:0] {
    BUS_INSTR = 2'd0,
    BUS_OPND  = 2'd1,
    BUS_DATA  = 2'd2,
    BUS_NONE  = 2'd3
  } brk_bus_e;

  // per-pair configuration, bit order matches the control word field
  typedef struct packed {
    logic     men_hi;
    logic     men_lo;
    logic     rng;
    brk_bus_e sel;
  } pair_cfg_t;

  localparam int PAIR_CFG_W  = $bits(pair_cfg_t);
  localparam int PAIR_STRIDE = 8;

endpackage

// File: rtl/brk_cfg_regs.sv
`timescale 1ns/1ps
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NPAIR = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [2*NPAIR-1:0][DW-1:0] pt_q,
  output logic [2*NPAIR-1:0][DW-1:0] mk_q,
  output pair_cfg_t [NPAIR-1:0]     pcfg_q,
  output logic                      comb_q,
  output logic [DW-1:0]             ctrl_rd
);

  localparam int NCMP     = 2 * NPAIR;
  localparam int A_PT     = 0;
  localparam int A_MK     = NCMP;
  localparam int A_CTRL   = 2 * NCMP;
  localparam int COMB_BIT = PAIR_STRIDE * NPAIR;

  logic ctrl_wr;
  assign ctrl_wr = we && (addr == AW'(A_CTRL));

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp_regs
    logic pt_wr, mk_wr;
    assign pt_wr = we && (addr == AW'(A_PT + c));
    assign mk_wr = we && (addr == AW'(A_MK + c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pt_q[c] <= '0;
        mk_q[c] <= '0;
      end else begin
        if (pt_wr) pt_q[c] <= wdata;
        if (mk_wr) mk_q[c] <= wdata;
      end
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcfg_q[p] <= '{men_hi: 1'b0, men_lo: 1'b0, rng: 1'b0, sel: BUS_NONE};
      end else if (ctrl_wr) begin
        pcfg_q[p] <= pair_cfg_t'(wdata[PAIR_STRIDE*p +: PAIR_CFG_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       comb_q <= 1'b0;
    else if (ctrl_wr) comb_q <= wdata[COMB_BIT];
  end

  always_comb begin
    ctrl_rd = '0;
    for (int p = 0; p < NPAIR; p++) begin
      ctrl_rd[PAIR_STRIDE*p +: PAIR_CFG_W] = pcfg_q[p];
    end
    ctrl_rd[COMB_BIT] = comb_q;
  end

  // R10: a control write is visible on the next cycle
  p_ctrl_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (comb_q == $past(wdata[COMB_BIT])));

endmodule

// File: rtl/brk_point_pair.sv
`timescale 1ns/1ps
module brk_point_pair
  import brk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pair_cfg_t          cfg,
  input  logic [1:0][DW-1:0] pt,
  input  logic [1:0][DW-1:0] mk,
  input  logic               i_vld,
  input  logic [DW-1:0]      i_val,
  input  logic               o_vld,
  input  logic [DW-1:0]      o_val,
  input  logic               d_vld,
  input  logic [DW-1:0]      d_val,
  output logic [1:0]         hit
);

  logic [DW-1:0] bus_v;
  logic          bus_ok;
  logic          in_rng;
  logic [1:0]    pt_eq;

  always_comb begin
    unique case (cfg.sel)
      BUS_INSTR: begin bus_v = i_val; bus_ok = i_vld; end
      BUS_OPND:  begin bus_v = o_val; bus_ok = o_vld; end
      BUS_DATA:  begin bus_v = d_val; bus_ok = d_vld; end
      default:   begin bus_v = '0;    bus_ok = 1'b0;  end
    endcase
  end

  assign in_rng = (bus_v >= pt[0]) && (bus_v <= pt[1]);

  for (genvar k = 0; k < 2; k++) begin : g_point
    logic          men;
    logic [DW-1:0] care;
    assign men      = (k == 0) ? cfg.men_lo : cfg.men_hi;
    assign care     = men ? ~mk[k] : '1;
    assign pt_eq[k] = ((bus_v ^ pt[k]) & care) == '0;
  end

  always_comb begin
    if (!bus_ok)      hit = 2'b00;
    else if (cfg.rng) hit = {2{in_rng}};
    else              hit = pt_eq;
  end

  // R3: an idle selected bus never produces a hit
  p_idle_instr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == BUS_INSTR && !i_vld) |-> (hit == 2'b00));
  p_idle_opnd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == BUS_OPND && !o_vld) |-> (hit == 2'b00));
  p_idle_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == BUS_DATA && !d_vld) |-> (hit == 2'b00));
  // R5: inverted range never matches; range hits come in pairs
  p_inverted_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rng && (pt[0] > pt[1])) |-> (hit == 2'b00));
  p_range_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rng |-> (hit[0] == hit[1]));

endmodule

// File: rtl/brk_status.sv
`timescale 1ns/1ps
module brk_status #(
  parameter int DW   = 32,
  parameter int NCMP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMP-1:0] set,
  input  logic [NCMP-1:0] clr,
  input  logic [DW-1:0]   ia,
  input  logic [DW-1:0]   oa,
  output logic [NCMP-1:0] status_q,
  output logic [DW-1:0]   cap_ia_q,
  output logic [DW-1:0]   cap_oa_q
);

  logic first_hit;
  assign first_hit = (|set) && (status_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      cap_ia_q <= '0;
      cap_oa_q <= '0;
    end else begin
      status_q <= (status_q & ~clr) | set;
      if (first_hit) begin
        cap_ia_q <= ia;
        cap_oa_q <= oa;
      end
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_chk
    // R7: sticky without a clear, and a hit beats a clear
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr[i]) |=> status_q[i]);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> status_q[i]);
  end

  // R8: captures frozen while anything is pending, and loaded on the first hit
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_q) |=> ($stable(cap_ia_q) && $stable(cap_oa_q)));
  p_cap_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set) && (status_q == '0)) |=> (cap_ia_q == $past(ia) && cap_oa_q == $past(oa)));

endmodule

// File: rtl/brk_cmp_group.sv
`timescale 1ns/1ps
module brk_cmp_group
  import brk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NPAIR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ifetch_vld,
  input  logic [DW-1:0] ifetch_addr,
  input  logic          opnd_vld,
  input  logic [DW-1:0] opnd_addr,
  input  logic          data_vld,
  input  logic [DW-1:0] data_val,
  output logic          brk_irq
);

  localparam int NCMP   = 2 * NPAIR;
  localparam int A_PT   = 0;
  localparam int A_MK   = NCMP;
  localparam int A_CTRL = 2 * NCMP;
  localparam int A_STAT = A_CTRL + 1;
  localparam int A_CIA  = A_CTRL + 2;
  localparam int A_COA  = A_CTRL + 3;

  logic [NCMP-1:0][DW-1:0] pt_q, mk_q;
  pair_cfg_t [NPAIR-1:0]   pcfg_q;
  logic                    comb_q;
  logic [DW-1:0]           ctrl_rd;
  logic [NCMP-1:0]         raw_hit, set_vec, clr_vec, status_q;
  logic [DW-1:0]           cap_ia_q, cap_oa_q;

  brk_cfg_regs #(.DW(DW), .AW(AW), .NPAIR(NPAIR)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pt_q    (pt_q),
    .mk_q    (mk_q),
    .pcfg_q  (pcfg_q),
    .comb_q  (comb_q),
    .ctrl_rd (ctrl_rd)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    brk_point_pair #(.DW(DW)) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (pcfg_q[p]),
      .pt    (pt_q[2*p+1:2*p]),
      .mk    (mk_q[2*p+1:2*p]),
      .i_vld (ifetch_vld),
      .i_val (ifetch_addr),
      .o_vld (opnd_vld),
      .o_val (opnd_addr),
      .d_vld (data_vld),
      .d_val (data_val),
      .hit   (raw_hit[2*p+1:2*p])
    );
  end

  // joining: pair 0 (address side) and pair 1 (data side) must both hit
  logic both_pairs;
  assign both_pairs = (|raw_hit[1:0]) && (|raw_hit[3:2]);
  assign set_vec    = (comb_q && !both_pairs) ? '0 : raw_hit;

  assign clr_vec = (reg_we && reg_addr == AW'(A_STAT)) ? reg_wdata[NCMP-1:0] : '0;

  brk_status #(.DW(DW), .NCMP(NCMP)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (set_vec),
    .clr      (clr_vec),
    .ia       (ifetch_addr),
    .oa       (opnd_addr),
    .status_q (status_q),
    .cap_ia_q (cap_ia_q),
    .cap_oa_q (cap_oa_q)
  );

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCMP; c++) begin
      if (reg_addr == AW'(A_PT + c)) reg_rdata = pt_q[c];
      if (reg_addr == AW'(A_MK + c)) reg_rdata = mk_q[c];
    end
    if (reg_addr == AW'(A_CTRL)) reg_rdata = ctrl_rd;
    if (reg_addr == AW'(A_STAT)) reg_rdata = DW'(status_q);
    if (reg_addr == AW'(A_CIA))  reg_rdata = cap_ia_q;
    if (reg_addr == AW'(A_COA))  reg_rdata = cap_oa_q;
  end

  assign brk_irq = |status_q;

  // R6: with pairs joined, a lone-pair hit never reaches status
  p_combine_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_q && !((|raw_hit[1:0]) && (|raw_hit[3:2]))) |=> ($past(status_q) & ~$past(clr_vec)) == status_q);
  // R9: interrupt rises only after some hit was recorded
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_irq) |-> $past(|set_vec));

endmodule

// File: tb/brk_cmp_group_tb_top.sv
`timescale 1ns/1ps
module brk_cmp_group_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd9;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ifetch_vld = 1'b0, opnd_vld = 1'b0, data_vld = 1'b0;
  logic [31:0] ifetch_addr = '0, opnd_addr = '0, data_val = '0;
  logic        brk_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_pt [4];
  logic [31:0] m_mk [4];
  logic [31:0] m_ctrl;
  logic [3:0]  m_st;
  logic [31:0] m_cia, m_coa;

  always #2 clk = ~clk;

  brk_cmp_group dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ifetch_vld(ifetch_vld), .ifetch_addr(ifetch_addr),
    .opnd_vld(opnd_vld), .opnd_addr(opnd_addr),
    .data_vld(data_vld), .data_val(data_val), .brk_irq(brk_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_hits();
    logic [3:0] h = '0;
    for (int p = 0; p < 2; p++) begin
      logic [1:0] sel = m_ctrl[8*p +: 2];
      logic [31:0] v = '0;
      logic ok = 1'b0;
      case (sel)
        2'd0: begin v = ifetch_addr; ok = ifetch_vld; end
        2'd1: begin v = opnd_addr;   ok = opnd_vld;   end
        2'd2: begin v = data_val;    ok = data_vld;   end
        default: ok = 1'b0;
      endcase
      if (ok) begin
        if (m_ctrl[8*p+2]) begin
          logic r = (v >= m_pt[2*p]) && (v <= m_pt[2*p+1]);
          h[2*p] = r; h[2*p+1] = r;
        end else begin
          for (int k = 0; k < 2; k++) begin
            int c = 2*p + k;
            logic [31:0] ign = m_ctrl[8*p+3+k] ? m_mk[c] : 32'h0;
            h[c] = ((v ^ m_pt[c]) & ~ign) == 32'h0;
          end
        end
      end
    end
    if (m_ctrl[16] && !((|h[1:0]) && (|h[3:2]))) h = '0;
    return h;
  endfunction

  // one clock: model next state from current inputs, then check at +1ns
  task automatic cyc(string tag);
    logic [3:0] h = m_hits();
    logic [3:0] clr = (reg_we && reg_addr == 4'd9) ? reg_wdata[3:0] : 4'h0;
    logic [3:0] nst = (m_st & ~clr) | h;
    if ((|h) && m_st == 4'h0) begin m_cia = ifetch_addr; m_coa = opnd_addr; end
    if (reg_we) begin
      if (reg_addr < 4) m_pt[reg_addr[1:0]] = reg_wdata;
      else if (reg_addr < 8) m_mk[reg_addr[1:0]] = reg_wdata;
      else if (reg_addr == 8) m_ctrl = reg_wdata & 32'h0001_1F1F;
    end
    m_st = nst;
    @(posedge clk); #1;
    if (reg_addr == 4'd9) chk({tag, " status(R7)"}, reg_rdata, {28'h0, m_st});
    chk("R9 irq", {31'h0, brk_irq}, {31'h0, |m_st});
  endtask

  task automatic idle();
    ifetch_vld = 0; opnd_vld = 0; data_vld = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    cyc("wr");
    reg_we = 1'b0; reg_addr = 4'd9;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    reg_addr = a; #0.2;
    chk(tag, reg_rdata, exp);
    reg_addr = 4'd9;
  endtask

  task automatic hit_i(logic [31:0] v, string tag);
    ifetch_addr = v; ifetch_vld = 1'b1; cyc(tag); idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin m_pt[c] = '0; m_mk[c] = '0; end
    m_ctrl = 32'h0000_0303; m_st = '0; m_cia = '0; m_coa = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.2;
    // R1: reset state
    rd("R1 status", 4'd9, 32'h0);
    rd("R1 cap ia", 4'd10, 32'h0);
    rd("R1 cap oa", 4'd11, 32'h0);
    chk("R1 irq", {31'h0, brk_irq}, 32'h0);
    rd("R10 ctrl reset", 4'd8, 32'h0000_0303);

    // R2 point hit on instruction bus, R8 capture
    wr(0, 32'h1000); wr(1, 32'h2000); wr(8, 32'h0000_0300);
    opnd_addr = 32'hAAAA_0000;
    hit_i(32'h1000, "R2 point0");
    rd("R2 status bit0", 4'd9, 32'h1);
    rd("R8 cap ia", 4'd10, 32'h1000);
    rd("R8 cap oa", 4'd11, 32'hAAAA_0000);
    opnd_addr = 32'hBBBB_0000;
    hit_i(32'h2000, "R2 point1");
    rd("R2 both bits", 4'd9, 32'h3);
    rd("R8 cap ia kept", 4'd10, 32'h1000);
    rd("R8 cap oa kept", 4'd11, 32'hAAAA_0000);
    wr(9, 32'h3);
    rd("R7 cleared", 4'd9, 32'h0);

    // R3 no valid, wrong bus
    ifetch_addr = 32'h1000; ifetch_vld = 0; cyc("R3 no valid");
    opnd_addr = 32'h1000; opnd_vld = 1; cyc("R3 wrong bus"); idle();
    rd("R3 status", 4'd9, 32'h0);

    // R4 masks
    wr(0, 32'h1200); wr(4, 32'h0000_00FF); wr(8, 32'h0000_0308);
    hit_i(32'h12AB, "R4 masked hit");
    rd("R4 masked hit", 4'd9, 32'h1);
    wr(9, 32'h1);
    hit_i(32'h13AB, "R4 unmasked miss");
    rd("R4 unmasked miss", 4'd9, 32'h0);
    wr(8, 32'h0000_0300);
    hit_i(32'h12AB, "R4 mask disabled");
    rd("R4 mask disabled", 4'd9, 32'h0);

    // R5 range
    wr(0, 32'h100); wr(1, 32'h200); wr(8, 32'h0000_0304);
    hit_i(32'h100, "R5 lower bound"); rd("R5 lower bound", 4'd9, 32'h3); wr(9, 32'h3);
    hit_i(32'h200, "R5 upper bound"); rd("R5 upper bound", 4'd9, 32'h3); wr(9, 32'h3);
    hit_i(32'h201, "R5 above");       rd("R5 above", 4'd9, 32'h0);
    hit_i(32'hFF,  "R5 below");       rd("R5 below", 4'd9, 32'h0);
    wr(0, 32'h200); wr(1, 32'h100);
    hit_i(32'h180, "R5 inverted");    rd("R5 inverted", 4'd9, 32'h0);
    hit_i(32'h200, "R5 inverted edge"); rd("R5 inverted edge", 4'd9, 32'h0);

    // R6 combined operand address + data value
    wr(0, 32'h40); wr(1, 32'h41); wr(2, 32'h55); wr(3, 32'h56);
    wr(8, 32'h0001_0201);
    opnd_addr = 32'h40; opnd_vld = 1; cyc("R6 addr only"); idle();
    data_val = 32'h55; data_vld = 1; cyc("R6 data only"); idle();
    rd("R6 one side", 4'd9, 32'h0);
    opnd_vld = 1; data_vld = 1; ifetch_addr = 32'h7777; cyc("R6 both"); idle();
    rd("R6 both", 4'd9, 32'h5);
    rd("R8 cap ia combined", 4'd10, 32'h7777);

    // R7 clear colliding with a new hit
    reg_addr = 4'd9; reg_wdata = 32'h1; reg_we = 1; opnd_vld = 1; data_vld = 1;
    cyc("R7 collision"); reg_we = 0; idle();
    rd("R7 hit beats clear", 4'd9, 32'h5);
    wr(9, 32'h2); rd("R7 zero write no effect", 4'd9, 32'h5);
    wr(9, 32'h1); rd("R7 clear bit0", 4'd9, 32'h4);
    wr(9, 32'h4); rd("R7 clear bit2", 4'd9, 32'h0);

    // R10 readback
    rd("R10 pt2", 4'd2, 32'h55);
    rd("R10 mk0", 4'd4, 32'hFF);
    wr(8, 32'hFFFF_FFFF); rd("R10 ctrl defined bits", 4'd8, 32'h0001_1F1F);
    rd("R10 unmapped", 4'd15, 32'h0);

    // random phase
    for (int blk = 0; blk < 60; blk++) begin
      logic [31:0] ctl;
      idle();
      for (int c = 0; c < 4; c++) begin
        wr(4'(c), 32'($urandom_range(0, 15)) << 4);
        wr(4'(4 + c), ($urandom_range(0, 2) == 0) ? 32'($urandom) : 32'h0000_000F);
      end
      ctl = 32'($urandom) & 32'h0000_1F1F;
      if ($urandom_range(0, 3) == 0) ctl = (ctl & 32'h0000_1C1C) | 32'h0001_0201;
      wr(8, ctl);
      rd("R10 ctrl random", 4'd8, m_ctrl);
      for (int c = 0; c < 4; c++) rd("R10 pt random", 4'(c), m_pt[c]);
      for (int t = 0; t < 30; t++) begin
        ifetch_vld = 1'($urandom); ifetch_addr = 32'($urandom_range(0, 255));
        opnd_vld   = 1'($urandom); opnd_addr   = 32'($urandom_range(0, 255));
        data_vld   = 1'($urandom); data_val    = 32'($urandom_range(0, 255));
        reg_addr = 4'd9;
        reg_we = ($urandom_range(0, 5) == 0);
        reg_wdata = 32'($urandom_range(0, 15));
        cyc("R2 random");
        reg_we = 0;
      end
      idle();
      rd("R8 random cap ia", 4'd10, m_cia);
      rd("R8 random cap oa", 4'd11, m_coa);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule